// File: doc/BRIEF.md
# SECDED Hamming Codec for 32-bit Words

This block pairs a combinational encoder with a combinational decoder for a single-error-correct, double-error-detect Hamming code. The code protects a 32-bit data word with 7 check bits. The encoder turns a data word into its check field. The stored or transmitted codeword is the check field placed above the data, `{chk, data}`, so codeword bits 0..31 are data and bits 32..38 are check bits.

The decoder takes a received data word, a received check field and a mode bit. It returns the data, corrected when correction is allowed, together with two flags: one for a corrected single error and one for a detected double error. The encoder and decoder have independent ports, so a user can close the loop through a storage element or an error-injection path.

Six of the check bits are Hamming parity bits over the data. The seventh is the overall parity of the word. With the overall parity bit, the decoder can tell an odd number of flips from a nonzero-syndrome even number of flips.

Top module: `secded_codec`

## Requirements
- R1: Data bit i has Hamming position hpos(i), the (i+1)-th integer of 3 or more that is not a power of two, so data bit 0 is at 3 and data bit 31 is at 38. Check bit j (j = 0..5) is the XOR of all data bits whose hpos has bit j set. Check bit 6 is the XOR of all 32 data bits and check bits 0..5, which gives even parity over the 39-bit codeword.
- R2: When the received codeword matches a valid encoding, the data output equals the received data and both flags are low, in either mode.
- R3: With mode 0 and exactly one flipped bit among codeword bits 0..38, the data output equals the original data, the single flag is 1 and the double flag is 0.
- R4: With mode 0 and one flipped bit in a check position (codeword bits 32..38), the data output equals the received data, which is the original, and the single flag is 1.
- R5: With two flipped bits at distinct codeword positions, in either mode, the double flag is 1, the single flag is 0 and the data output equals the received data without any bit changed.
- R6: With mode 1 (detect only), a single flipped bit is not corrected. The data output equals the received data and both flags are low.
- R7: The single flag and the double flag are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| enc_data_i | input | 32 | Data word to encode |
| enc_chk_o | output | 7 | Check field for enc_data_i |
| dec_data_i | input | 32 | Received data word |
| dec_chk_i | input | 7 | Received check field |
| dec_mode_i | input | 1 | 0: correct single errors; 1: detect only |
| dec_data_o | output | 32 | Decoded (possibly corrected) data |
| dec_single_o | output | 1 | A single error was corrected |
| dec_double_o | output | 1 | A double error was detected |

## Verification
The assertions assume that at most two codeword bits differ from a valid encoding. The decoder's behaviour for three or more flips is not defined, so the checks about single and double classification would be meaningless there. The clean-word assertion also assumes that, whenever the encoder and decoder see the same data, the decoder's check field is meant to be the encoder's output. The stimulus always builds the received word by taking the encoder's output for a chosen data word and flipping zero, one or two distinct positions, where the second position is always chosen different from the first.

// File: rtl/secded_pkg.sv
package secded_pkg;

   typedef enum logic [1:0] {
      ERR_NONE   = 2'd0,
      ERR_SINGLE = 2'd1,
      ERR_DOUBLE = 2'd2
   } err_kind_e;

   // Number of Hamming parity bits needed for a given data width.
   function automatic int ham_bits(input int data_w);
      int p;
      p = 0;
      for (int k = 1; k < 16; k++) begin
         if (p == 0 && (1 << k) >= data_w + k + 1) p = k;
      end
      return p;
   endfunction

   // Hamming position of data bit idx: the idx-th non-power-of-two from 3 up.
   function automatic int data_pos(input int idx);
      int n;
      int res;
      n   = 0;
      res = 0;
      for (int p = 3; p < 1024; p++) begin
         if (((p & (p - 1)) != 0) && res == 0) begin
            if (n == idx) res = p;
            n++;
         end
      end
      return res;
   endfunction

endpackage

// File: rtl/secded_parity.sv
module secded_parity #(
   parameter int DATA_W = 32,
   parameter int HAM_W  = 6
) (
   input  logic [DATA_W-1:0] data_i,
   output logic [HAM_W-1:0]  par_o
);

   function automatic logic [DATA_W-1:0] cover_mask(input int j);
      logic [DATA_W-1:0] m;
      for (int i = 0; i < DATA_W; i++) begin
         m[i] = ((secded_pkg::data_pos(i) >> j) & 1) != 0;
      end
      return m;
   endfunction

   for (genvar j = 0; j < HAM_W; j++) begin : g_par
      localparam logic [DATA_W-1:0] MASK = cover_mask(j);
      assign par_o[j] = ^(data_i & MASK);
   end

endmodule

// File: rtl/secded_classify.sv
module secded_classify #(
   parameter int HAM_W   = 6,
   parameter int MAX_POS = 38
) (
   input  logic [HAM_W-1:0]      syn_i,
   input  logic                  odd_i,
   output secded_pkg::err_kind_e kind_o
);

   localparam logic [HAM_W:0] MAXP = (HAM_W+1)'(MAX_POS);

   logic pos_ok;
   assign pos_ok = ({1'b0, syn_i} <= MAXP);

   always_comb begin
      if (!odd_i && syn_i == '0)  kind_o = secded_pkg::ERR_NONE;
      else if (odd_i && pos_ok)   kind_o = secded_pkg::ERR_SINGLE;
      else                        kind_o = secded_pkg::ERR_DOUBLE;
   end

endmodule

// File: rtl/secded_fix.sv
module secded_fix #(
   parameter int DATA_W = 32,
   parameter int HAM_W  = 6
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic [HAM_W-1:0]  syn_i,
   input  logic              fix_en_i,
   output logic [DATA_W-1:0] data_o
);

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      localparam logic [HAM_W-1:0] POS = HAM_W'(secded_pkg::data_pos(i));
      assign data_o[i] = data_i[i] ^ (fix_en_i && (syn_i == POS));
   end

endmodule

// File: rtl/secded_codec.sv
module secded_codec #(
   parameter int DATA_W = 32,
   parameter int CHK_W  = 7
) (
   input  logic [DATA_W-1:0] enc_data_i,
   output logic [CHK_W-1:0]  enc_chk_o,
   input  logic [DATA_W-1:0] dec_data_i,
   input  logic [CHK_W-1:0]  dec_chk_i,
   input  logic              dec_mode_i,
   output logic [DATA_W-1:0] dec_data_o,
   output logic              dec_single_o,
   output logic              dec_double_o
);

   localparam int HAM_W   = CHK_W - 1;
   localparam int MAX_POS = DATA_W + HAM_W;

   if (DATA_W < 4) begin : g_bad_width
      $error("secded_codec: DATA_W must be at least 4");
   end
   if (CHK_W != secded_pkg::ham_bits(DATA_W) + 1) begin : g_bad_chk
      $error("secded_codec: CHK_W does not match DATA_W");
   end

   // Encoder path
   logic [HAM_W-1:0] enc_ham;

   secded_parity #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_enc_par (
      .data_i (enc_data_i),
      .par_o  (enc_ham)
   );

   assign enc_chk_o = {(^enc_data_i) ^ (^enc_ham), enc_ham};

   // Decoder path
   logic [HAM_W-1:0]      dec_ham;
   logic [HAM_W-1:0]      syn;
   logic                  odd;
   logic                  fix_en;
   secded_pkg::err_kind_e kind;

   secded_parity #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_dec_par (
      .data_i (dec_data_i),
      .par_o  (dec_ham)
   );

   assign syn = dec_ham ^ dec_chk_i[HAM_W-1:0];
   assign odd = (^dec_data_i) ^ (^dec_chk_i);

   secded_classify #(.HAM_W(HAM_W), .MAX_POS(MAX_POS)) u_cls (
      .syn_i  (syn),
      .odd_i  (odd),
      .kind_o (kind)
   );

   assign fix_en = !dec_mode_i && (kind == secded_pkg::ERR_SINGLE);

   secded_fix #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_fix (
      .data_i   (dec_data_i),
      .syn_i    (syn),
      .fix_en_i (fix_en),
      .data_o   (dec_data_o)
   );

   assign dec_single_o = fix_en;
   assign dec_double_o = (kind == secded_pkg::ERR_DOUBLE);

endmodule

// File: rtl/secded_codec_chk.sv
module secded_codec_chk #(
   parameter int DATA_W = 32,
   parameter int CHK_W  = 7
) (
   input logic [DATA_W-1:0] enc_data_i,
   input logic [CHK_W-1:0]  enc_chk_o,
   input logic [DATA_W-1:0] dec_data_i,
   input logic [CHK_W-1:0]  dec_chk_i,
   input logic              dec_mode_i,
   input logic [DATA_W-1:0] dec_data_o,
   input logic              dec_single_o,
   input logic              dec_double_o
);

   always_comb begin
      // R2: a word equal to the encoder's output decodes clean
      if (enc_data_i == dec_data_i && enc_chk_o == dec_chk_i) begin
         p_clean_word_r2: assert (dec_data_o == dec_data_i && !dec_single_o && !dec_double_o);
      end
      // R4: single fault with matching data lies in the check field; data untouched
      if (dec_single_o && enc_data_i == dec_data_i) begin
         p_chk_fault_r4: assert (dec_data_o == dec_data_i);
      end
      // R5: a double error never modifies the data
      if (dec_double_o) begin
         p_no_fix_double_r5: assert (dec_data_o == dec_data_i);
      end
      // R6: detect-only mode neither corrects nor reports a single error
      if (dec_mode_i) begin
         p_detect_mode_r6: assert (!dec_single_o && dec_data_o == dec_data_i);
      end
      // R7: flags are exclusive
      p_flags_excl_r7: assert (!(dec_single_o && dec_double_o));
   end

endmodule

bind secded_codec secded_codec_chk #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_chk (
   .enc_data_i   (enc_data_i),
   .enc_chk_o    (enc_chk_o),
   .dec_data_i   (dec_data_i),
   .dec_chk_i    (dec_chk_i),
   .dec_mode_i   (dec_mode_i),
   .dec_data_o   (dec_data_o),
   .dec_single_o (dec_single_o),
   .dec_double_o (dec_double_o)
);

// File: tb/sim_secded_codec.sv
`timescale 1ns/1ps
module sim_secded_codec;

   logic        clk = 1'b0;
   logic [31:0] enc_data_i = '0;
   logic [6:0]  enc_chk_o;
   logic [31:0] dec_data_i = '0;
   logic [6:0]  dec_chk_i = '0;
   logic        dec_mode_i = 1'b0;
   logic [31:0] dec_data_o;
   logic        dec_single_o;
   logic        dec_double_o;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   secded_codec u0 (
      .enc_data_i   (enc_data_i),
      .enc_chk_o    (enc_chk_o),
      .dec_data_i   (dec_data_i),
      .dec_chk_i    (dec_chk_i),
      .dec_mode_i   (dec_mode_i),
      .dec_data_o   (dec_data_o),
      .dec_single_o (dec_single_o),
      .dec_double_o (dec_double_o)
   );

   function automatic int hpos(input int idx);
      int n;
      int res;
      n   = 0;
      res = 0;
      for (int p = 3; p < 64; p++) begin
         if (p != 4 && p != 8 && p != 16 && p != 32 && res == 0) begin
            if (n == idx) res = p;
            n++;
         end
      end
      return res;
   endfunction

   function automatic logic [6:0] model_chk(input logic [31:0] d);
      logic [6:0] c;
      c = '0;
      for (int j = 0; j < 6; j++) begin
         for (int i = 0; i < 32; i++) begin
            if (((hpos(i) >> j) & 1) != 0) c[j] = c[j] ^ d[i];
         end
      end
      c[6] = (^d) ^ (^c[5:0]);
      return c;
   endfunction

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // nflip: 0, 1 or 2 flips at codeword positions p1, p2
   task automatic apply(input logic [31:0] d, input int nflip, input int p1, input int p2,
                        input logic mode);
      logic [38:0] cw;
      logic [31:0] exp_d;
      logic        exp_s;
      logic        exp_dd;
      string       req;
      @(posedge clk);
      enc_data_i = d;
      #1;
      check({25'd0, enc_chk_o}, {25'd0, model_chk(d)}, "R1");
      cw = {enc_chk_o, d};
      if (nflip >= 1) cw[p1] = ~cw[p1];
      if (nflip == 2) cw[p2] = ~cw[p2];
      dec_data_i = cw[31:0];
      dec_chk_i  = cw[38:32];
      dec_mode_i = mode;
      if (nflip == 0) begin
         req = "R2"; exp_d = d; exp_s = 1'b0; exp_dd = 1'b0;
      end else if (nflip == 1 && !mode) begin
         req = (p1 >= 32) ? "R4" : "R3"; exp_d = d; exp_s = 1'b1; exp_dd = 1'b0;
      end else if (nflip == 1) begin
         req = "R6"; exp_d = cw[31:0]; exp_s = 1'b0; exp_dd = 1'b0;
      end else begin
         req = "R5"; exp_d = cw[31:0]; exp_s = 1'b0; exp_dd = 1'b1;
      end
      @(negedge clk);
      check(dec_data_o, exp_d, {req, " data"});
      check({31'd0, dec_single_o}, {31'd0, exp_s}, {req, " single"});
      check({31'd0, dec_double_o}, {31'd0, exp_dd}, {req, " double"});
      check({31'd0, dec_single_o & dec_double_o}, 32'd0, "R7 exclusive");
   endtask

   initial begin
      int unsigned seed;
      seed = $urandom(32'd20240611);
      repeat (2) @(posedge clk);
      // Reset / idle state: all-zero inputs decode clean (R2)
      @(negedge clk);
      check(dec_data_o, 32'd0, "R2 idle data");
      check({30'd0, dec_single_o, dec_double_o}, 32'd0, "R2 idle flags");
      // Directed corner cases
      apply(32'h0000_0000, 0, 0, 0, 1'b0);
      apply(32'hFFFF_FFFF, 0, 0, 0, 1'b1);
      apply(32'h0000_0000, 1, 0, 0, 1'b0);
      apply(32'hFFFF_FFFF, 1, 38, 0, 1'b0);
      apply(32'hA5A5_5A5A, 1, 31, 0, 1'b0);
      apply(32'h1234_5678, 1, 32, 0, 1'b0);
      apply(32'h1234_5678, 1, 5, 0, 1'b1);
      apply(32'hDEAD_BEEF, 2, 0, 38, 1'b0);
      apply(32'hDEAD_BEEF, 2, 32, 33, 1'b1);
      apply(32'h0000_0001, 2, 37, 38, 1'b0);
      // Exhaustive single-position sweep in both modes
      for (int p = 0; p < 39; p++) begin
         apply($urandom, 1, p, 0, 1'b0);
         apply($urandom, 1, p, 0, 1'b1);
      end
      // Constrained random mix
      for (int k = 0; k < 400; k++) begin
         int a;
         int b;
         a = $urandom_range(38);
         b = (a + 1 + $urandom_range(37)) % 39;
         apply($urandom, $urandom_range(2), a, b, $urandom_range(1));
      end
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule